// File: doc/BRIEF.md
# Memory-Mapped Event Timer Register Block

This block holds the register file and the free-running main counter of a high-resolution event timer. Software reaches it through one 64-bit port: a write strobe, a read strobe, a byte address and write data. Read data comes back one cycle after the read strobe. Alongside the counter it holds a read-only capability word, a global configuration word and a write-one-to-clear interrupt status word. It also holds three comparator channels, each with its own configuration word and comparator word.

Each channel raises its status bit when the running counter equals its comparator. A status bit that is set and enabled drives one of 32 interrupt lines, chosen by the channel's route field. Legacy routing overrides that choice for the first two channels and sends them to lines 0 and 8. A periodic-capable channel advances its comparator by the last value software wrote to it each time it fires. A single global enable bit halts the counter and silences every interrupt line.

Top module: `evt_timer_regs`

## Requirements
- R1: The word at byte offset 0x000 is read-only and reads as follows. Bits 63:32 hold the tick period in femtoseconds (default 20,000,000). Bits 31:16 hold the vendor ID (default 0x1D5A). Bit 15 is 1 (legacy routing supported). Bit 14 is 0. Bit 13 is 1 (64-bit counter). Bits 12:8 hold the channel count minus one. Bits 7:0 hold a non-zero revision (default 1).
- R2: The global configuration word at 0x010 stores bit 0 (global enable) and bit 1 (legacy routing). All other bits read zero, and both stored bits reset to 0.
- R3: The 64-bit main counter at 0x0F0 resets to 0 and is writable. A written value appears in the cycle after the write strobe. While the global enable is 1, the counter rises by exactly one every cycle in which it is not written.
- R4: While the global enable is 0, the counter holds its value and all 32 interrupt lines are low, whatever the status bits hold.
- R5: Channel N's configuration word sits at 0x100+0x20*N and its comparator at 0x108+0x20*N. The comparator resets to all ones. Status bit N, at 0x020, is set in the cycle after the counter equals comparator N. This requires the global enable to be 1 and configuration bit 2 (interrupt enable) to be 1. In one-shot mode the comparator keeps its value.
- R6: Writing the status word clears each bit written as 1. Bits written as 0 keep their value.
- R7: Channel configuration bits 13:9 select the interrupt line. The selected line is high one cycle after the channel's status bit is set and enabled, and falls one cycle after that condition ends.
- R8: With legacy routing on, channel 0 drives line 0 and channel 1 drives line 8, regardless of their route fields. Channel 2 keeps its own route field.
- R9: Configuration bit 4 reads 1 only on periodic-capable channels; by default only channel 2 is periodic-capable. Bit 3 selects periodic mode and stays 0 on other channels. Bit 5 always reads 1. In periodic mode, each match adds the last written comparator value to the comparator.
- R10: Every other offset reads zero, including 0x110+0x20*N. Writes to those offsets change no register.
- R11: If a status bit is set by a match in the same cycle software writes 1 to clear it, the bit ends up set.
- R12: Read data is registered and shows the addressed word in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Byte address, 8-byte aligned |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Registered read data |
| irq_lines | output | 32 | Registered interrupt lines |

## Verification
Random counter values written while the block is halted must read back exactly, which separates loading from counting. Paired reads with known gaps separate a counter that steps by exactly one from one that skips or stalls. Directed one-shot, legacy and periodic runs separate the route-field line from the fixed legacy lines, and a one-shot comparator from one that advances by the written period. A status clear landing exactly on the match cycle, compared with a clear one cycle later, separates set-priority from clear-priority. Random writes to reserved offsets must leave zeros on readback and leave the configuration unchanged.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int WORD_W     = 64;
  localparam int ROUTE_W    = 5;
  // word (8-byte) indices of the fixed registers
  localparam int W_CAP      = 'h000 >> 3;
  localparam int W_CFG      = 'h010 >> 3;
  localparam int W_STAT     = 'h020 >> 3;
  localparam int W_CNT      = 'h0F0 >> 3;
  localparam int W_CH_BASE  = 'h100 >> 3;
  localparam int W_CH_STEP  = 'h020 >> 3;

  // channel configuration bit positions
  localparam int B_INT_EN   = 2;
  localparam int B_PERIODIC = 3;
  localparam int B_PER_CAP  = 4;
  localparam int B_WIDE_CAP = 5;
  localparam int B_ROUTE_LO = 9;

  function automatic logic [WORD_W-1:0] cap_word(input logic [31:0] period_fs,
                                                 input logic [15:0] vendor,
                                                 input int          num_ch,
                                                 input logic [7:0]  rev);
    logic [WORD_W-1:0] w;
    w         = '0;
    w[63:32]  = period_fs;
    w[31:16]  = vendor;
    w[15]     = 1'b1;
    w[13]     = 1'b1;
    w[12:8]   = 5'(num_ch - 1);
    w[7:0]    = rev;
    return w;
  endfunction
endpackage

// File: rtl/evt_channel.sv
module evt_channel
  import evt_timer_pkg::*;
#(
  parameter bit PER_CAP = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] counter,
  input  logic              gen_en,
  input  logic              cnt_wr,
  input  logic              cfg_wr,
  input  logic              cmp_wr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] cfg_rd,
  output logic [WORD_W-1:0] cmp_rd,
  output logic              int_en,
  output logic [ROUTE_W-1:0] route,
  output logic              set_evt
);
  logic              int_en_q;
  logic              per_q;
  logic [ROUTE_W-1:0] route_q;
  logic [WORD_W-1:0] cmp_q;
  logic [WORD_W-1:0] period_q;
  logic              match;

  assign match   = gen_en && !cnt_wr && (counter == cmp_q);
  assign set_evt = match && int_en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      int_en_q <= 1'b0;
      per_q    <= 1'b0;
      route_q  <= '0;
      cmp_q    <= '1;
      period_q <= '0;
    end else begin
      if (cfg_wr) begin
        int_en_q <= wdata[B_INT_EN];
        per_q    <= PER_CAP && wdata[B_PERIODIC];
        route_q  <= wdata[B_ROUTE_LO +: ROUTE_W];
      end
      if (cmp_wr) begin
        cmp_q    <= wdata;
        period_q <= wdata;
      end else if (match && per_q) begin
        cmp_q    <= cmp_q + period_q;
      end
    end
  end

  always_comb begin
    cfg_rd                        = '0;
    cfg_rd[B_INT_EN]              = int_en_q;
    cfg_rd[B_PERIODIC]            = per_q;
    cfg_rd[B_PER_CAP]             = PER_CAP;
    cfg_rd[B_WIDE_CAP]            = 1'b1;
    cfg_rd[B_ROUTE_LO +: ROUTE_W] = route_q;
  end

  assign cmp_rd = cmp_q;
  assign int_en = int_en_q;
  assign route  = route_q;
endmodule

// File: rtl/evt_irq_router.sv
module evt_irq_router
  import evt_timer_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int LEG_LINE0 = 0,
  parameter int LEG_LINE1 = 8,
  localparam int NLINES = 2 ** ROUTE_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       gen_en,
  input  logic                       legacy,
  input  logic [NUM_CH-1:0]          status,
  input  logic [NUM_CH-1:0]          int_en,
  input  logic [NUM_CH*ROUTE_W-1:0]  routes,
  output logic [NLINES-1:0]          irq_q
);
  logic [NLINES-1:0] lines;

  always_comb begin
    lines = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      logic [ROUTE_W-1:0] idx;
      idx = routes[ch*ROUTE_W +: ROUTE_W];
      if (legacy && ch == 0) idx = ROUTE_W'(LEG_LINE0);
      if (legacy && ch == 1) idx = ROUTE_W'(LEG_LINE1);
      if (gen_en && status[ch] && int_en[ch]) lines[idx] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= lines;
  end
endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
  import evt_timer_pkg::*;
#(
  parameter int          NUM_CH    = 3,
  parameter int          ADDR_W    = 12,
  parameter logic [31:0] PERIOD_FS = 32'd20_000_000,
  parameter logic [15:0] VENDOR_ID = 16'h1D5A,
  parameter logic [7:0]  REV_ID    = 8'h01,
  parameter logic [31:0] PER_CAPS  = 32'h0000_0004,
  localparam int         NLINES    = 2 ** ROUTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [63:0]       wdata,
  output logic [63:0]       rdata,
  output logic [NLINES-1:0] irq_lines
);
  localparam int WIDX_W = ADDR_W - 3;
  localparam logic [WORD_W-1:0] CAP = cap_word(PERIOD_FS, VENDOR_ID, NUM_CH, REV_ID);

  logic [WIDX_W-1:0] widx;
  logic              gen_en_q, legacy_q;
  logic [WORD_W-1:0] count_q;
  logic [NUM_CH-1:0] stat_q, stat_set, stat_clr, ch_int_en;
  logic [NUM_CH*ROUTE_W-1:0] ch_route;
  logic [WORD_W-1:0] ch_cfg_rd [NUM_CH];
  logic [WORD_W-1:0] ch_cmp_rd [NUM_CH];
  logic [NUM_CH-1:0] ch_cfg_wr, ch_cmp_wr;
  logic              cfg_wr, stat_wr, cnt_wr;
  logic [WORD_W-1:0] rd_mux, rdata_q;

  assign widx    = addr[ADDR_W-1:3];
  assign cfg_wr  = wr_en && widx == WIDX_W'(W_CFG);
  assign stat_wr = wr_en && widx == WIDX_W'(W_STAT);
  assign cnt_wr  = wr_en && widx == WIDX_W'(W_CNT);
  assign stat_clr = stat_wr ? wdata[NUM_CH-1:0] : '0;

  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      localparam int W_CFG_N = W_CH_BASE + n * W_CH_STEP;
      assign ch_cfg_wr[n] = wr_en && widx == WIDX_W'(W_CFG_N);
      assign ch_cmp_wr[n] = wr_en && widx == WIDX_W'(W_CFG_N + 1);

      evt_channel #(.PER_CAP(PER_CAPS[n])) u_ch (
        .clk     (clk),
        .rst     (rst),
        .counter (count_q),
        .gen_en  (gen_en_q),
        .cnt_wr  (cnt_wr),
        .cfg_wr  (ch_cfg_wr[n]),
        .cmp_wr  (ch_cmp_wr[n]),
        .wdata   (wdata),
        .cfg_rd  (ch_cfg_rd[n]),
        .cmp_rd  (ch_cmp_rd[n]),
        .int_en  (ch_int_en[n]),
        .route   (ch_route[n*ROUTE_W +: ROUTE_W]),
        .set_evt (stat_set[n])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_en_q <= 1'b0;
      legacy_q <= 1'b0;
      count_q  <= '0;
      stat_q   <= '0;
    end else begin
      if (cfg_wr) begin
        gen_en_q <= wdata[0];
        legacy_q <= wdata[1];
      end
      if (cnt_wr)        count_q <= wdata;
      else if (gen_en_q) count_q <= count_q + 1'b1;
      // set has priority over clear
      stat_q <= (stat_q & ~stat_clr) | stat_set;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (widx == WIDX_W'(W_CAP))  rd_mux = CAP;
    if (widx == WIDX_W'(W_CFG))  rd_mux = {62'd0, legacy_q, gen_en_q};
    if (widx == WIDX_W'(W_STAT)) rd_mux = WORD_W'(stat_q);
    if (widx == WIDX_W'(W_CNT))  rd_mux = count_q;
    for (int n = 0; n < NUM_CH; n++) begin
      if (widx == WIDX_W'(W_CH_BASE + n * W_CH_STEP))     rd_mux = ch_cfg_rd[n];
      if (widx == WIDX_W'(W_CH_BASE + n * W_CH_STEP + 1)) rd_mux = ch_cmp_rd[n];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end
  assign rdata = rdata_q;

  evt_irq_router #(.NUM_CH(NUM_CH)) u_router (
    .clk    (clk),
    .rst    (rst),
    .gen_en (gen_en_q),
    .legacy (legacy_q),
    .status (stat_q),
    .int_en (ch_int_en),
    .routes (ch_route),
    .irq_q  (irq_lines)
  );
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
  import evt_timer_pkg::*;
#(
  parameter int          NUM_CH    = 3,
  parameter int          ADDR_W    = 12,
  parameter logic [31:0] PERIOD_FS = 32'd20_000_000,
  parameter logic [15:0] VENDOR_ID = 16'h1D5A,
  parameter logic [7:0]  REV_ID    = 8'h01
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [63:0]       wdata,
  input logic [63:0]       rdata,
  input logic [31:0]       irq_lines,
  input logic              gen_en,
  input logic [63:0]       counter,
  input logic [NUM_CH-1:0] status,
  input logic [NUM_CH-1:0] set_vec
);
  localparam logic [63:0] CAPW = cap_word(PERIOD_FS, VENDOR_ID, NUM_CH, REV_ID);
  logic cnt_wr, stat_wr, cap_rd;
  assign cnt_wr  = wr_en && addr[ADDR_W-1:3] == (ADDR_W-3)'(W_CNT);
  assign stat_wr = wr_en && addr[ADDR_W-1:3] == (ADDR_W-3)'(W_STAT);
  assign cap_rd  = rd_en && addr[ADDR_W-1:3] == (ADDR_W-3)'(W_CAP);

  a_r4_counter_halted: assert property (@(posedge clk) disable iff (rst)
    (!gen_en && !cnt_wr) |=> counter == $past(counter));
  a_r3_counter_steps: assert property (@(posedge clk) disable iff (rst)
    (gen_en && !cnt_wr) |=> counter == $past(counter) + 64'd1);
  a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> counter == $past(wdata));
  a_r4_irq_masked: assert property (@(posedge clk) disable iff (rst)
    !gen_en |=> irq_lines == 32'd0);
  a_r1_cap_read: assert property (@(posedge clk) disable iff (rst)
    cap_rd |=> rdata == CAPW);

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_bit
      a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_vec[i] |=> status[i]);
      a_r6_w1c: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && wdata[i] && !set_vec[i]) |=> !status[i]);
    end
  endgenerate
endmodule

bind evt_timer_regs evt_timer_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .PERIOD_FS(PERIOD_FS),
  .VENDOR_ID(VENDOR_ID), .REV_ID(REV_ID)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .irq_lines(irq_lines), .gen_en(gen_en_q),
  .counter(count_q), .status(stat_q), .set_vec(stat_set)
);

// File: tb/evt_timer_regs_bench.sv
`timescale 1ns/1ps
module evt_timer_regs_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic [31:0] irq_lines;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  evt_timer_regs u_evt_timer_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_lines(irq_lines)
  );

  function automatic logic [63:0] exp_cap();
    return {32'd20_000_000, 16'h1D5A, 1'b1, 1'b0, 1'b1, 5'd2, 8'h01};
  endfunction
  function automatic logic [11:0] ch_cfg(input int n); return 12'(256 + 32*n); endfunction
  function automatic logic [11:0] ch_cmp(input int n); return 12'(264 + 32*n); endfunction
  function automatic logic [63:0] cfgv(input bit ie, input bit per, input int route);
    return (64'(ie) << 2) | (64'(per) << 3) | (64'(route) << 9);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] v, v2;
    void'($urandom(32'd7));
    idle(3); rst = 1'b0; idle(1);

    // reset state
    rd(12'h000, v); chk("R1 cap word", v, exp_cap());
    rd(12'h010, v); chk("R2 config reset", v, 64'd0);
    rd(12'h0F0, v); idle(5); rd(12'h0F0, v2);
    chk("R4 counter halted after reset", v2, 64'd0);
    chk("R4 irq low after reset", 64'(irq_lines), 64'd0);
    rd(12'h108, v); chk("R5 comparator reset all ones", v, '1);

    // R3 random load/readback while halted
    for (int i = 0; i < 8; i++) begin
      logic [63:0] r;
      r = {$urandom, $urandom};
      wr(12'h0F0, r); rd(12'h0F0, v); chk("R3 counter load", v, r);
    end

    // R3 counting rate
    wr(12'h0F0, 64'd0); wr(12'h010, 64'd1);
    rd(12'h0F0, v); rd(12'h0F0, v2); chk("R3 step of one", v2 - v, 64'd1);
    rd(12'h0F0, v); idle(10); rd(12'h0F0, v2); chk("R3 step over gap", v2 - v, 64'd11);
    rd(12'h010, v); chk("R2 enable readback", v, 64'd1);

    // R5/R7 one-shot on channel 0 routed to line 5
    wr(12'h010, 64'd0); wr(12'h0F0, 64'd100);
    wr(ch_cmp(0), 64'd110); wr(ch_cfg(0), cfgv(1, 0, 5));
    wr(12'h010, 64'd1); idle(30);
    rd(12'h020, v); chk("R5 status bit0 set", v, 64'd1);
    rd(ch_cmp(0), v); chk("R5 one-shot comparator kept", v, 64'd110);
    chk("R7 route field line 5", 64'(irq_lines), 64'h20);

    // R4 global disable masks lines
    wr(12'h010, 64'd0); idle(2);
    chk("R4 lines masked when disabled", 64'(irq_lines), 64'd0);
    wr(12'h010, 64'd1); idle(2);
    chk("R7 line restored", 64'(irq_lines), 64'h20);

    // R6 W1C
    wr(12'h020, 64'd0); rd(12'h020, v); chk("R6 zero write keeps", v, 64'd1);
    wr(12'h020, 64'd1); rd(12'h020, v); chk("R6 one write clears", v, 64'd0);
    idle(1); chk("R7 line falls", 64'(irq_lines), 64'd0);

    // R8 legacy routing
    wr(12'h010, 64'd0); wr(12'h0F0, 64'd0);
    wr(ch_cmp(1), 64'd5); wr(ch_cfg(1), cfgv(1, 0, 3)); wr(ch_cmp(0), 64'd6);
    wr(12'h010, 64'd3); idle(20);
    chk("R8 legacy lines 0 and 8", 64'(irq_lines), 64'h101);
    wr(12'h010, 64'd1); idle(2);
    chk("R8 legacy off uses routes", 64'(irq_lines), 64'h28);
    wr(12'h020, 64'd7);

    // R9 periodic
    wr(12'h010, 64'd0);
    wr(ch_cfg(2), cfgv(1, 1, 7)); rd(ch_cfg(2), v);
    chk("R9 ch2 cfg readback", v, cfgv(1, 1, 7) | 64'h30);
    wr(ch_cfg(0), cfgv(1, 1, 5)); rd(ch_cfg(0), v);
    chk("R9 ch0 periodic bit stays 0", v, cfgv(1, 0, 5) | 64'h20);
    wr(12'h0F0, 64'd0); wr(ch_cmp(2), 64'd40);
    wr(12'h010, 64'd1); idle(55);
    rd(ch_cmp(2), v); chk("R9 comparator advanced by period", v, 64'd80);
    rd(12'h020, v); chk("R9 periodic status", v[2], 64'd1);
    idle(40);
    rd(ch_cmp(2), v); chk("R9 second advance", v, 64'd120);
    wr(12'h010, 64'd0); wr(12'h020, 64'd7);

    // R11 set and clear in same cycle
    wr(12'h0F0, 64'd1000); wr(ch_cmp(0), 64'd1006);
    wr(12'h010, 64'd1); idle(6); wr(12'h020, 64'd1);
    rd(12'h020, v); chk("R11 same-cycle set wins", v[0], 64'd1);
    wr(12'h010, 64'd0); wr(12'h020, 64'd7);
    wr(12'h0F0, 64'd1000);
    wr(12'h010, 64'd1); idle(7); wr(12'h020, 64'd1);
    rd(12'h020, v); chk("R11 later clear takes effect", v[0], 64'd0);
    wr(12'h010, 64'd0);

    // R10 reserved offsets
    for (int i = 0; i < 6; i++) begin
      logic [11:0] a;
      a = 12'((5 + ($urandom % 25)) * 8);
      wr(a, {$urandom, $urandom});
      rd(a, v); chk("R10 reserved reads zero", v, 64'd0);
    end
    wr(12'h110, '1); rd(12'h110, v); chk("R10 route slot reads zero", v, 64'd0);
    rd(12'h010, v); chk("R10 config untouched", v, 64'd0);

    // R2 reserved config bits, R12 latency
    wr(12'h010, '1); rd(12'h010, v); chk("R2 only low two bits", v, 64'd3);
    wr(12'h010, 64'd0);
    addr = 12'h000; rd_en = 1'b1; @(posedge clk); #1; rd_en = 1'b0; addr = 12'h010;
    chk("R12 data one cycle after strobe", rdata, exp_cap());
    @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule